// File: doc/BRIEF.md
# Indirect Meter Parameter Access Port

This block holds the configuration of a bank of two-rate traffic meters and lets software reach it through three registers instead of one address per parameter. Every meter has a commit rate and a peak rate. For each rate there are four parameter kinds: a small mode field, a token rate, a bucket-size shift and a bucket counter. Software picks one entry with a single command word that packs the read/write flag, the parameter kind, the meter group, the meter index and the rate selector. It then polls a done flag in the same word.

To update an entry, software first places the value in the low data register (and, for the counter, its upper bits in the high data register), then writes the command word with the write flag set. To fetch an entry, it writes the command word with the write flag clear. Once done is set, the value sits in the low data register and, for the counter, in the high one. The table access runs a fixed number of cycles after the command write. Register writes during that window are dropped.

Top module: `mtr_param_port`

## Requirements
- R1: The command register (byte offset 0x4) reads back bit 31 = write flag, bit 30 = done, bits 29:28 = parameter kind, bits 27:26 = group, bits 23:17 = index, bit 16 = rate (0 commit, 1 peak). All other bits read zero.
- R2: Writing the command register clears done. Done returns to 1 exactly ACC_LAT (default 2) clock edges after the edge that took the command, and is never set while an access is pending.
- R3: A write command stores the low data register (offset 0x8) into the addressed entry. The value is truncated to the kind's width.
- R4: A read command loads the addressed entry into the low data register, and its bits above 31 into the high data register (offset 0xC), by the time done is set.
- R5: Kind widths are: 0 = mode, 3 bits (bit 0 tick select, bit 1 packet mode, bit 2 enable); 1 = token rate, 24 bits; 2 = bucket shift, 5 bits; 3 = bucket counter, 40 bits, with bits 39:32 taken from and returned in high-data bits 7:0. Unused bits read zero.
- R6: Every combination of group, index, rate and kind is a separate entry.
- R7: An index of DEPTH (default 8) or more reads as zero, and a write to it changes no entry.
- R8: While an access is pending, writes to the command, low-data and high-data registers are ignored.
- R9: After reset every entry, the command register and both data registers read zero, and done is 0.
- R10: Offsets other than 0x4, 0x8 and 0xC read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
Register reads are combinational, so a value written at one edge is readable half a cycle later. Done falls at the edge that takes the command and rises ACC_LAT edges later. The bench checks done at each of the half-cycle points after a command, so one cycle too early or too late is reported. In the sweeps, every read-data check is taken only after done has been seen set, which is the point where R4 makes the result due.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int REG_AW = 4;
    localparam int CNT_W  = 40;
    localparam int GRP_W  = 2;
    localparam int IDX_W  = 7;
    localparam int NUM_GROUPS = 1 << GRP_W;
    localparam int NUM_KINDS  = 4;

    localparam logic [REG_AW-1:0] OFS_CMD = 4'h4;
    localparam logic [REG_AW-1:0] OFS_DLO = 4'h8;
    localparam logic [REG_AW-1:0] OFS_DHI = 4'hC;

    typedef enum logic [1:0] {
        PK_MODE  = 2'd0,
        PK_RATE  = 2'd1,
        PK_SHIFT = 2'd2,
        PK_COUNT = 2'd3
    } pkind_e;

    typedef enum logic {
        RT_COMMIT = 1'b0,
        RT_PEAK   = 1'b1
    } rsel_e;

    typedef struct packed {
        logic             wr;
        pkind_e           kind;
        logic [GRP_W-1:0] group;
        logic [IDX_W-1:0] index;
        rsel_e            rate;
    } cmd_t;

    function automatic int kind_width(input int k);
        case (k)
            0:       return 3;
            1:       return 24;
            2:       return 5;
            default: return CNT_W;
        endcase
    endfunction

    function automatic cmd_t unpack_cmd(input logic [31:0] w);
        cmd_t c;
        c.wr    = w[31];
        c.kind  = pkind_e'(w[29:28]);
        c.group = w[27:26];
        c.index = w[23:17];
        c.rate  = rsel_e'(w[16]);
        return c;
    endfunction

    function automatic logic [31:0] pack_cmd(input cmd_t c, input logic done);
        logic [31:0] w;
        w        = '0;
        w[31]    = c.wr;
        w[30]    = done;
        w[29:28] = c.kind;
        w[27:26] = c.group;
        w[23:17] = c.index;
        w[16]    = c.rate;
        return w;
    endfunction

endpackage

// File: rtl/mtr_addr_map.sv
module mtr_addr_map
    import mtr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int ENTRIES = NUM_GROUPS * DEPTH * 2,
    localparam int AW = $clog2(ENTRIES)
) (
    input  cmd_t          cmd,
    output logic [AW-1:0] addr,
    output logic          in_range
);

    int lin;

    always_comb begin
        in_range = (int'(cmd.index) < DEPTH);
        lin      = ((int'(cmd.group) * DEPTH) + int'(cmd.index)) * 2 + int'(cmd.rate);
        addr     = in_range ? AW'(lin) : '0;
    end

endmodule

// File: rtl/mtr_param_store.sv
module mtr_param_store
    import mtr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int ENTRIES = NUM_GROUPS * DEPTH * 2,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  pkind_e           kind,
    input  logic [AW-1:0]    addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata
);

    logic [CNT_W-1:0] rd_k [NUM_KINDS];

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        localparam int W = kind_width(k);
        logic [W-1:0] mem [ENTRIES];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int e = 0; e < ENTRIES; e++) begin
                    mem[e] <= '0;
                end
            end else if (we && (int'(kind) == k)) begin
                mem[addr] <= wdata[W-1:0];
            end
        end

        assign rd_k[k] = CNT_W'(mem[addr]);
    end

    assign rdata = rd_k[kind];

endmodule

// File: rtl/mtr_cmd_seq.sv
module mtr_cmd_seq #(
    parameter int ACC_LAT = 2,
    localparam int CW = $clog2(ACC_LAT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic fire
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            cnt  <= CW'(ACC_LAT - 1);
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign fire = busy && (cnt == '0);

endmodule

// File: rtl/mtr_param_port.sv
module mtr_param_port
    import mtr_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ACC_LAT = 2,
    localparam int ENTRIES = NUM_GROUPS * DEPTH * 2,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    cmd_t             cmd_q;
    logic [31:0]      dlo_q;
    logic [31:0]      dhi_q;
    logic             busy;
    logic             done;
    logic             fire;
    logic             wr_ok;
    logic             start;
    logic [AW-1:0]    tbl_addr;
    logic             in_range;
    logic [CNT_W-1:0] tbl_rdata;
    logic [CNT_W-1:0] tbl_wdata;
    logic             tbl_we;

    assign wr_ok = reg_wr && !busy;
    assign start = wr_ok && (reg_addr == OFS_CMD);

    mtr_cmd_seq #(.ACC_LAT(ACC_LAT)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done),
        .fire  (fire)
    );

    mtr_addr_map #(.DEPTH(DEPTH)) u_map (
        .cmd      (cmd_q),
        .addr     (tbl_addr),
        .in_range (in_range)
    );

    assign tbl_we    = fire && cmd_q.wr && in_range;
    assign tbl_wdata = {dhi_q[CNT_W-33:0], dlo_q};

    mtr_param_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .kind  (cmd_q.kind),
        .addr  (tbl_addr),
        .wdata (tbl_wdata),
        .rdata (tbl_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            dlo_q <= '0;
            dhi_q <= '0;
        end else if (wr_ok) begin
            case (reg_addr)
                OFS_CMD: cmd_q <= unpack_cmd(reg_wdata);
                OFS_DLO: dlo_q <= reg_wdata;
                OFS_DHI: dhi_q <= reg_wdata;
                default: ;
            endcase
        end else if (fire && !cmd_q.wr) begin
            if (in_range) begin
                dlo_q <= tbl_rdata[31:0];
                dhi_q <= 32'(tbl_rdata[CNT_W-1:32]);
            end else begin
                dlo_q <= '0;
                dhi_q <= '0;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CMD: reg_rdata = pack_cmd(cmd_q, done);
            OFS_DLO: reg_rdata = dlo_q;
            OFS_DHI: reg_rdata = dhi_q;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mtr_param_chk.sv
module mtr_param_chk
    import mtr_pkg::*;
#(
    parameter int ACC_LAT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              busy,
    input logic              done,
    input cmd_t              cmd_q,
    input logic [31:0]       dlo_q
);

    logic       started;
    logic [7:0] lat_cnt;

    assign started = !busy && reg_wr && (reg_addr == OFS_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt <= '0;
        end else if (started) begin
            lat_cnt <= 8'd1;
        end else if (busy && lat_cnt != 8'hFF) begin
            lat_cnt <= lat_cnt + 8'd1;
        end
    end

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_CMD) |-> (reg_rdata[25:24] == 2'b00 && reg_rdata[15:0] == 16'h0));

    assert_done_visible_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_CMD) |-> (reg_rdata[30] == done));

    assert_done_clears_R2: assert property (@(posedge clk) disable iff (rst)
        started |=> (!done && busy));

    assert_done_latency_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (lat_cnt == 8'(ACC_LAT + 1)));

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q));

    assert_dlo_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_q.wr) |=> $stable(dlo_q));

endmodule

bind mtr_param_port mtr_param_chk #(.ACC_LAT(ACC_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .done      (done),
    .cmd_q     (cmd_q),
    .dlo_q     (dlo_q)
);

// File: tb/mtr_param_port_bench.sv
module mtr_param_port_bench;

    localparam int DEPTH = 8;
    localparam int ACC_LAT = 2;
    localparam logic [3:0] A_CMD = 4'h4;
    localparam logic [3:0] A_DLO = 4'h8;
    localparam logic [3:0] A_DHI = 4'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mtr_param_port #(.DEPTH(DEPTH), .ACC_LAT(ACC_LAT)) u_mtr_param_port (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v;
        bit seen = 1'b0;
        for (int n = 0; n < 20; n++) begin
            rd(A_CMD, v);
            if (v[30]) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(req, 32'(seen), 32'd1);
    endtask

    function automatic logic [31:0] mk(input bit w, input int k, input int g, input int i, input int r);
        logic [31:0] c;
        c = '0;
        c[31] = w;
        c[29:28] = 2'(k);
        c[27:26] = 2'(g);
        c[23:17] = 7'(i);
        c[16] = r[0];
        return c;
    endfunction

    function automatic logic [31:0] pat(input int g, input int i, input int r, input int k);
        logic [31:0] s;
        s = 32'(g * 1000 + i * 37 + r * 501 + k * 7919 + 1);
        return s * 32'h9E3779B1;
    endfunction

    function automatic logic [31:0] lo_mask(input int k);
        case (k)
            0: return 32'h0000_0007;
            1: return 32'h00FF_FFFF;
            2: return 32'h0000_001F;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] elo;
        logic [31:0] ehi;
        string tag;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9: registers after reset
        rd(A_CMD, v); check("R9 cmd", v, 32'h0);
        rd(A_DLO, v); check("R9 dlo", v, 32'h0);
        rd(A_DHI, v); check("R9 dhi", v, 32'h0);

        // R2: done timing for a read command; also R9 untouched entry is zero
        wr(A_CMD, mk(0, 1, 1, 3, 1));
        rd(A_CMD, v); check("R2 done low after 1 edge", 32'(v[30]), 32'd0);
        @(negedge clk);
        rd(A_CMD, v); check("R2 done low after 2 edges", 32'(v[30]), 32'd0);
        @(negedge clk);
        rd(A_CMD, v); check("R2 done high after 3 edges", 32'(v[30]), 32'd1);
        rd(A_DLO, v); check("R9 entry zero", v, 32'h0);

        // R10: unmapped offsets
        wr(4'h0, 32'hDEAD_BEEF);
        rd(4'h0, v); check("R10 offset 0", v, 32'h0);
        rd(4'h2, v); check("R10 offset 2", v, 32'h0);

        // Sweep writes: R3 R5 R6 R7
        for (int g = 0; g < 4; g++)
            for (int i = 0; i < DEPTH + 2; i++)
                for (int r = 0; r < 2; r++)
                    for (int k = 0; k < 4; k++) begin
                        wr(A_DLO, pat(g, i, r, k));
                        wr(A_DHI, ~pat(g, i, r, k));
                        wr(A_CMD, mk(1, k, g, i, r));
                        wait_done("R2 write done");
                    end

        // Sweep reads: R4 with R3 R5 R6 R7
        for (int g = 0; g < 4; g++)
            for (int i = 0; i < DEPTH + 2; i++)
                for (int r = 0; r < 2; r++)
                    for (int k = 0; k < 4; k++) begin
                        wr(A_CMD, mk(0, k, g, i, r));
                        wait_done("R2 read done");
                        if (i >= DEPTH) begin
                            elo = 32'h0; ehi = 32'h0; tag = "R7";
                        end else begin
                            elo = pat(g, i, r, k) & lo_mask(k);
                            ehi = (k == 3) ? ((~pat(g, i, r, k)) & 32'hFF) : 32'h0;
                            tag = (k == 3) ? "R5" : ((r == 1) ? "R6" : "R3");
                        end
                        rd(A_DLO, v); check({tag, " R4 low"}, v, elo);
                        rd(A_DHI, v); check({tag, " R4 high"}, v, ehi);
                    end

        // R8: writes while pending are ignored
        wr(A_DLO, 32'h0012_3456);
        wr(A_CMD, mk(1, 1, 0, 0, 0));
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_DLO; reg_wdata = 32'h00AB_CDEF;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_done("R8 done");
        rd(A_DLO, v); check("R8 dlo kept", v, 32'h0012_3456);
        wr(A_CMD, mk(0, 1, 0, 0, 0));
        // second command during the pending window must not replace the first
        reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = mk(0, 2, 3, 7, 1);
        @(negedge clk);
        reg_wr = 1'b0;
        wait_done("R8 done 2");
        rd(A_CMD, v); check("R8 cmd kept", v, mk(0, 1, 0, 0, 0) | 32'h4000_0000);
        rd(A_DLO, v); check("R8 entry value", v, 32'h0012_3456);

        // R1: field packing with all bits set (index 127 is out of range)
        wr(A_CMD, 32'hFFFF_FFFF);
        wait_done("R1 done");
        rd(A_CMD, v); check("R1 readback", v, 32'hFCFF_0000);
        wr(A_CMD, mk(0, 3, 3, 127, 1));
        wait_done("R7 done");
        rd(A_DLO, v); check("R7 far index low", v, 32'h0);
        rd(A_DHI, v); check("R7 far index high", v, 32'h0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule